// File: doc/BRIEF.md
# Zero-Turnaround Late-Write SRAM Core

This block is a synchronous single-port memory whose address, control and write data are all taken in on rising clock edges. Write data is due later than its command, by the same number of cycles as the read latency. A stream of reads and writes in any order therefore keeps the shared data bus busy on every cycle, with no idle cycle when the direction changes. The data bus is split into a data input, a data output and an output-drive qualifier, so that the block can sit inside a larger chip.

A static mode input is captured at reset and selects one of two timings. In pipelined timing a read has a two-cycle latency and write data is sampled two clock-enabled edges after its command. In flow-through timing both paths are one cycle shorter. A write whose data has been sampled waits in a posted register until the next enabled edge. Each read merges bytes from that register, and in pipelined timing also from the write data arriving on the bus in the same cycle. A read therefore always returns the result of every write issued before it, taking the newest bytes first. A clock enable freezes the whole block. A two-bit burst counter lets a command continue at the next address without a new address being presented.

Top module: `ztsram_core`

## Requirements
- R1: Reset (`rst` high on a clock edge) leaves `dq_oe_o` low and every pipeline stage and the burst state holding "no operation". `mode_flow_i` is captured only while reset is high, and changing it later has no effect on timing.
- R2: In pipelined mode (`mode_flow_i` = 0 at reset), a read issued at enabled edge E drives its data on `dq_o` with `dq_oe_o` high during the interval after enabled edge E+1.
- R3: In pipelined mode, the write data of a write issued at enabled edge E is sampled from `dq_i` at enabled edge E+2.
- R4: In flow-through mode (`mode_flow_i` = 1 at reset), a read issued at enabled edge E drives its data during the interval right after edge E, and write data for a write issued at E is sampled at edge E+1.
- R5: With `adv_ld_n_i` low, the block is selected only when `sel1_n_i`=0, `sel2_i`=1 and `sel3_n_i`=0. When selected, `we_n_i`=1 issues a read and `we_n_i`=0 issues a write. When not selected, nothing is read, nothing is written and the bus is not driven.
- R6: `lane_en_n_i[i]` is active low and governs data bits [9i+8:9i]. Lanes whose enable is high keep their old contents, and a write with all four enables high changes nothing.
- R7: While `clk_en_n_i` is high, clock edges change no state. A read whose data is on the bus keeps driving the same value, and a write data interval keeps the bus undriven.
- R8: `oe_n_i` is asynchronous and active low. While it is high, `dq_oe_o` is low. A read during which it is high still completes: it is a dummy read.
- R9: `dq_oe_o` is never high in an interval that carries write data.
- R10: A read returns, lane by lane, the newest data of all writes issued before it, including writes whose data has not yet reached the array.
- R11: With `adv_ld_n_i` high, the block repeats the last loaded operation (read, write or none) at an address whose upper bits are unchanged and whose low two bits are incremented modulo 4. A continued write uses the current lane enables.
- R12: Reads and writes can be issued on consecutive enabled edges in any order, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_flow_i | input | 1 | Timing select captured at reset: 1 = flow-through, 0 = pipelined |
| clk_en_n_i | input | 1 | Active-low clock enable; high freezes all state |
| sel1_n_i | input | 1 | Select, active low |
| sel2_i | input | 1 | Select, active high |
| sel3_n_i | input | 1 | Select, active low |
| we_n_i | input | 1 | Write enable, active low |
| adv_ld_n_i | input | 1 | Low loads a new command and address; high continues the burst |
| lane_en_n_i | input | NLANE | Active-low write enable, one per 9-bit lane |
| addr_i | input | ADDR_W | Word address |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_i | input | NLANE*LANE_W | Write data bus |
| dq_o | output | NLANE*LANE_W | Read data bus |
| dq_oe_o | output | 1 | High when `dq_o` should drive the shared bus |

## Verification
Every result is tied to a count of clock-enabled edges, not to raw clock cycles. Read data is due in the interval after enabled edge E+1 in pipelined mode and right after edge E in flow-through mode. Write data must be present in that same interval, ahead of the sampling edge. The bench keeps an eight-entry ring indexed by enabled-edge count, filling it when each command is issued and draining it as edges occur. In each interval it drives the write data found there, waits one time unit after the falling edge and compares the bus against the ring entry. Stalled edges leave the count unchanged, so the same expectation is checked again for as long as the stall lasts.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;

    localparam int unsigned LANE_BITS  = 9;
    localparam int unsigned LANES      = 4;
    localparam int unsigned ADDR_BITS  = 6;
    localparam int unsigned BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // all three selects must be in their active state
    function automatic logic chip_selected(input logic s1_n, input logic s2, input logic s3_n);
        return !s1_n && s2 && !s3_n;
    endfunction

    // linear burst step, wraps inside the low address bits
    function automatic logic [BURST_BITS-1:0] burst_step(input logic [BURST_BITS-1:0] cur);
        return cur + {{(BURST_BITS-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/ztsram_cmd.sv
module ztsram_cmd
    import ztsram_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_BITS,
    parameter int unsigned NLANE  = LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              we_n,
    input  logic              adv_ld_n,
    input  logic [NLANE-1:0]  lane_en_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NLANE-1:0]  mask_q
);

    op_e               burst_op;
    op_e               nxt_op;
    logic [ADDR_W-1:0] burst_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [NLANE-1:0]  nxt_mask;
    logic              sel_ok;

    always_comb begin
        sel_ok = chip_selected(sel1_n, sel2, sel3_n);
        if (!adv_ld_n) begin
            nxt_addr = addr;
            if (sel_ok) nxt_op = we_n ? OP_READ : OP_WRITE;
            else        nxt_op = OP_NONE;
        end else begin
            nxt_op   = burst_op;
            nxt_addr = {burst_addr[ADDR_W-1:BURST_BITS],
                        burst_step(burst_addr[BURST_BITS-1:0])};
        end
        nxt_mask = (nxt_op == OP_WRITE) ? ~lane_en_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q       <= OP_NONE;
            addr_q     <= '0;
            mask_q     <= '0;
            burst_op   <= OP_NONE;
            burst_addr <= '0;
        end else if (en) begin
            op_q       <= nxt_op;
            addr_q     <= nxt_addr;
            mask_q     <= nxt_mask;
            burst_op   <= nxt_op;
            burst_addr <= nxt_addr;
        end
    end

    a_r5_deselect_idles: assert property (@(posedge clk) disable iff (rst)
        (en && !adv_ld_n && !(!sel1_n && sel2 && !sel3_n)) |=> (op_q == OP_NONE));

    a_r11_burst_wraps: assert property (@(posedge clk) disable iff (rst)
        (en && adv_ld_n && burst_op != OP_NONE) |=>
        ((addr_q[1:0] == $past(burst_addr[1:0]) + 2'd1) &&
         (addr_q[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]))));

endmodule

// File: rtl/ztsram_store.sv
module ztsram_store
    import ztsram_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_BITS,
    parameter int unsigned NLANE  = LANES,
    parameter int unsigned LANE_W = LANE_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    cap_ok,
    input  logic [ADDR_W-1:0]       cap_addr,
    input  logic [NLANE-1:0]        cap_mask,
    input  logic [NLANE*LANE_W-1:0] cap_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [NLANE*LANE_W-1:0] rd_data
);

    localparam int unsigned DATA_W = NLANE * LANE_W;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_word;

    logic              post_ok;
    logic [ADDR_W-1:0] post_addr;
    logic [NLANE-1:0]  post_mask;
    logic [DATA_W-1:0] post_data;

    // posted write register: holds one sampled write until the next enabled edge
    always_ff @(posedge clk) begin
        if (rst) begin
            post_ok   <= 1'b0;
            post_addr <= '0;
            post_mask <= '0;
            post_data <= '0;
        end else if (en) begin
            post_ok   <= cap_ok && (cap_mask != '0);
            post_addr <= cap_addr;
            post_mask <= cap_mask;
            post_data <= cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && en && post_ok) begin
            for (int i = 0; i < int'(NLANE); i++) begin
                if (post_mask[i]) mem[post_addr][i*LANE_W +: LANE_W] <= post_data[i*LANE_W +: LANE_W];
            end
        end
    end

    assign mem_word = mem[rd_addr];

    // per-lane merge: arriving data beats posted data beats the array
    for (genvar g = 0; g < int'(NLANE); g++) begin : g_lane
        logic hit_cap;
        logic hit_post;
        assign hit_cap  = cap_ok && (cap_addr == rd_addr) && cap_mask[g];
        assign hit_post = post_ok && (post_addr == rd_addr) && post_mask[g];
        assign rd_data[g*LANE_W +: LANE_W] =
            hit_cap  ? cap_data[g*LANE_W +: LANE_W]  :
            hit_post ? post_data[g*LANE_W +: LANE_W] :
                       mem_word[g*LANE_W +: LANE_W];
    end

    a_r6_abort_not_posted: assert property (@(posedge clk) disable iff (rst)
        (en && cap_ok && cap_mask == '0) |=> !post_ok);

endmodule

// File: rtl/ztsram_core.sv
module ztsram_core
    import ztsram_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_BITS,
    parameter int unsigned NLANE  = LANES,
    parameter int unsigned LANE_W = LANE_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_flow_i,
    input  logic                    clk_en_n_i,
    input  logic                    sel1_n_i,
    input  logic                    sel2_i,
    input  logic                    sel3_n_i,
    input  logic                    we_n_i,
    input  logic                    adv_ld_n_i,
    input  logic [NLANE-1:0]        lane_en_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    oe_n_i,
    input  logic [NLANE*LANE_W-1:0] dq_i,
    output logic [NLANE*LANE_W-1:0] dq_o,
    output logic                    dq_oe_o
);

    localparam int unsigned DATA_W = NLANE * LANE_W;

    logic              en;
    logic              mode_q;
    op_e               op_a;
    logic [ADDR_W-1:0] addr_a;
    logic [NLANE-1:0]  mask_a;
    op_e               op_b;
    logic [ADDR_W-1:0] addr_b;
    logic [NLANE-1:0]  mask_b;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_merged;
    logic              cap_ok;
    logic [ADDR_W-1:0] cap_addr;
    logic [NLANE-1:0]  cap_mask;
    op_e               data_op;

    assign en = !clk_en_n_i;

    ztsram_cmd #(.ADDR_W(ADDR_W), .NLANE(NLANE)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sel1_n   (sel1_n_i),
        .sel2     (sel2_i),
        .sel3_n   (sel3_n_i),
        .we_n     (we_n_i),
        .adv_ld_n (adv_ld_n_i),
        .lane_en_n(lane_en_n_i),
        .addr     (addr_i),
        .op_q     (op_a),
        .addr_q   (addr_a),
        .mask_q   (mask_a)
    );

    // second stage: only the pipelined timing uses it for data
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= mode_flow_i;
            op_b    <= OP_NONE;
            addr_b  <= '0;
            mask_b  <= '0;
            rdata_q <= '0;
        end else if (en) begin
            op_b   <= op_a;
            addr_b <= addr_a;
            mask_b <= mask_a;
            if (op_a == OP_READ) rdata_q <= rd_merged;
        end
    end

    // the stage whose write data is on dq_i in this interval
    always_comb begin
        if (mode_q) begin
            cap_ok   = (op_a == OP_WRITE);
            cap_addr = addr_a;
            cap_mask = mask_a;
            data_op  = op_a;
        end else begin
            cap_ok   = (op_b == OP_WRITE);
            cap_addr = addr_b;
            cap_mask = mask_b;
            data_op  = op_b;
        end
    end

    ztsram_store #(.ADDR_W(ADDR_W), .NLANE(NLANE), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .cap_ok  (cap_ok),
        .cap_addr(cap_addr),
        .cap_mask(cap_mask),
        .cap_data(dq_i),
        .rd_addr (addr_a),
        .rd_data (rd_merged)
    );

    assign dq_o    = mode_q ? rd_merged : rdata_q;
    assign dq_oe_o = (data_op == OP_READ) && !oe_n_i;

    a_r7_stall_holds_data: assert property (@(posedge clk) disable iff (rst)
        (clk_en_n_i && dq_oe_o) |=> $stable(dq_o));

    a_r8_oe_forces_off: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !dq_oe_o);

    a_r9_write_slot_quiet: assert property (@(posedge clk) disable iff (rst)
        (data_op == OP_WRITE) |-> !dq_oe_o);

endmodule

// File: tb/ztsram_core_bench.sv
module ztsram_core_bench;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_flow_i;
    logic          clk_en_n_i;
    logic          sel1_n_i, sel2_i, sel3_n_i;
    logic          we_n_i, adv_ld_n_i, oe_n_i;
    logic [NL-1:0] lane_en_n_i;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] dq_i;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;

    always #4 clk = ~clk;

    ztsram_core #(.ADDR_W(AW), .NLANE(NL), .LANE_W(LW)) u_ztsram_core (
        .clk(clk), .rst(rst), .mode_flow_i(mode_flow_i), .clk_en_n_i(clk_en_n_i),
        .sel1_n_i(sel1_n_i), .sel2_i(sel2_i), .sel3_n_i(sel3_n_i), .we_n_i(we_n_i),
        .adv_ld_n_i(adv_ld_n_i), .lane_en_n_i(lane_en_n_i), .addr_i(addr_i),
        .oe_n_i(oe_n_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    int            errors = 0;
    int            checks = 0;
    int            done_e = 0;
    logic [DW-1:0] bmem [64];
    int            slot_op [8];
    logic [DW-1:0] slot_val [8];
    int            b_op = 0;
    logic [AW-1:0] b_addr = '0;
    logic          flow = 1'b0;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input string tag, input logic got_oe, input logic exp_oe,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp_d);
        checks++;
        if (got_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s: drive actual=%0b expected=%0b", tag, got_oe, exp_oe);
        end else if (exp_oe && got !== exp_d) begin
            errors++;
            $display("FAIL %s: data actual=%h expected=%h", tag, got, exp_d);
        end
    endtask

    // one interval: drive, check the current slot, model the command, take the edge
    task automatic step(input string tag, input logic stall, input logic s1n, input logic s2,
                        input logic s3n, input logic wen, input logic advn,
                        input logic [NL-1:0] ben, input logic [AW-1:0] a, input logic oen);
        int            cur;
        int            op;
        int            s;
        logic [AW-1:0] na;
        logic [NL-1:0] m;
        logic [DW-1:0] dat;
        logic          exp_oe;
        string         t;
        cur = done_e % 8;
        clk_en_n_i = stall; sel1_n_i = s1n; sel2_i = s2; sel3_n_i = s3n;
        we_n_i = wen; adv_ld_n_i = advn; lane_en_n_i = ben; addr_i = a; oe_n_i = oen;
        dq_i = (slot_op[cur] == 2) ? slot_val[cur] : DW'({$urandom(), $urandom()});
        #1;
        exp_oe = (slot_op[cur] == 1) && !oen;
        t = tag;
        if (t == "") begin
            if (slot_op[cur] == 2)              t = "R9";
            else if (slot_op[cur] == 1 && oen) t = "R8";
            else if (flow)                      t = "R4";
            else                                t = "R2";
        end
        check(t, dq_oe_o, exp_oe, dq_o, slot_val[cur]);
        if (!stall) begin
            if (!advn) begin
                na = a;
                op = (!s1n && s2 && !s3n) ? (wen ? 1 : 2) : 0;
            end else begin
                op = b_op;
                na = {b_addr[AW-1:2], b_addr[1:0] + 2'd1};
            end
            b_op = op; b_addr = na;
            slot_op[cur] = 0;
            done_e++;
            s = (done_e + (flow ? 0 : 1)) % 8;
            if (op == 2) begin
                m   = ~ben;
                dat = DW'({$urandom(), $urandom()});
                for (int i = 0; i < NL; i++) if (m[i]) bmem[na][i*LW +: LW] = dat[i*LW +: LW];
                slot_op[s] = 2; slot_val[s] = dat;
            end else if (op == 1) begin
                slot_op[s] = 1; slot_val[s] = bmem[na];
            end else begin
                slot_op[s] = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        step(tag, 0, 0, 1, 0, 1, 0, 4'hF, a, 0);
    endtask
    task automatic wr(input string tag, input logic [AW-1:0] a, input logic [NL-1:0] ben);
        step(tag, 0, 0, 1, 0, 0, 0, ben, a, 0);
    endtask
    task automatic idle(input string tag, input logic oen);
        step(tag, 0, 1, 1, 0, 1, 0, 4'hF, '0, oen);
    endtask
    task automatic cont(input string tag, input logic [NL-1:0] ben);
        step(tag, 0, 1, 0, 1, 1, 1, ben, '0, 0);
    endtask
    task automatic hold(input string tag);
        step(tag, 1, 0, 1, 0, 1, 0, 4'hF, '0, 0);
    endtask

    task automatic rand_step();
        logic [NL-1:0] ben;
        logic [AW-1:0] a;
        ben = (($urandom % 8) == 0) ? 4'hF : NL'($urandom);
        a   = (($urandom % 2) == 0) ? AW'($urandom % 8) : AW'($urandom);
        step("", (($urandom % 10) == 0), (($urandom % 12) == 0), (($urandom % 12) != 0),
             (($urandom % 12) == 0), 1'($urandom), (($urandom % 5) == 0), ben, a,
             (($urandom % 8) == 0));
    endtask

    task automatic do_reset(input logic to_flow);
        repeat (4) idle("", 0);
        rst = 1'b1; mode_flow_i = to_flow; clk_en_n_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        flow = to_flow; done_e = 0; b_op = 0; b_addr = '0;
        for (int i = 0; i < 8; i++) slot_op[i] = 0;
        #1;
        check("R1", dq_oe_o, 1'b0, dq_o, '0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin slot_op[i] = 0; slot_val[i] = '0; end
        for (int i = 0; i < 64; i++) bmem[i] = '0;
        rst = 1'b1; mode_flow_i = 1'b0; clk_en_n_i = 1'b0; sel1_n_i = 1'b1; sel2_i = 1'b0;
        sel3_n_i = 1'b1; we_n_i = 1'b1; adv_ld_n_i = 1'b0; lane_en_n_i = 4'hF;
        addr_i = '0; oe_n_i = 1'b0; dq_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", dq_oe_o, 1'b0, dq_o, '0);
        @(negedge clk);

        // pipelined: fill, then read back (R3 write data timing)
        for (int a = 0; a < 64; a++) wr("R3", AW'(a), 4'h0);
        for (int a = 0; a < 8; a++) rd("R3", AW'(a * 7));
        idle("R3", 0); idle("R3", 0);

        // R10: reads right behind writes to the same word
        wr("R10", 6'd5, 4'h0); rd("R10", 6'd5); rd("R10", 6'd5); rd("R10", 6'd5);
        wr("R10", 6'd5, 4'b1110); wr("R10", 6'd5, 4'b1101); rd("R10", 6'd5); rd("R10", 6'd5);
        idle("R10", 0); idle("R10", 0);

        // R6: abort and partial lanes
        wr("R6", 6'd9, 4'hF); rd("R6", 6'd9);
        wr("R6", 6'd9, 4'b0101); idle("R6", 0); rd("R6", 6'd9); idle("R6", 0); idle("R6", 0);

        // R5: writes while deselected must not land
        step("R5", 0, 1, 1, 0, 0, 0, 4'h0, 6'd10, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 4'h0, 6'd10, 0);
        step("R5", 0, 0, 1, 1, 0, 0, 4'h0, 6'd10, 0);
        rd("R5", 6'd10); idle("R5", 0); idle("R5", 0);

        // R7: stall while a read drives and while write data waits
        rd("R7", 6'd3); idle("R7", 0); hold("R7"); hold("R7"); hold("R7"); idle("R7", 0);
        wr("R7", 6'd3, 4'h0); idle("R7", 0); hold("R7"); hold("R7"); rd("R7", 6'd3);
        idle("R7", 0); idle("R7", 0);

        // R8: dummy read with output enable high, then a normal read
        rd("R8", 6'd4); idle("R8", 1); idle("R8", 1); rd("R8", 6'd4); idle("R8", 0); idle("R8", 0);

        // R11: read burst wrapping, write burst, deselect continue
        rd("R11", 6'd6); cont("R11", 4'hF); cont("R11", 4'hF); cont("R11", 4'hF); cont("R11", 4'hF);
        wr("R11", 6'd13, 4'h0); cont("R11", 4'b0011); cont("R11", 4'h0); cont("R11", 4'b1010);
        rd("R11", 6'd12); cont("R11", 4'hF); cont("R11", 4'hF); cont("R11", 4'hF);
        idle("R11", 0); cont("R11", 4'h0); cont("R11", 4'h0); rd("R11", 6'd13); idle("R11", 0); idle("R11", 0);

        // R12: alternating reads and writes, no gaps
        for (int i = 0; i < 12; i++) begin
            if (i % 2 == 0) rd("R12", AW'(i % 3)); else wr("R12", AW'(i % 3), NL'(i));
        end
        idle("R12", 0); idle("R12", 0);

        for (int i = 0; i < 1500; i++) rand_step();

        // flow-through timing; mode input changed after reset must not matter (R1)
        do_reset(1'b1);
        mode_flow_i = 1'b0;
        rd("R1", 6'd1); rd("R1", 6'd2); idle("R1", 0);
        wr("R4", 6'd20, 4'h0); rd("R4", 6'd20); rd("R4", 6'd20); idle("R4", 0);
        wr("R10", 6'd21, 4'b0110); rd("R10", 6'd21); wr("R10", 6'd21, 4'b1001); rd("R10", 6'd21);
        idle("R10", 0);
        rd("R7", 6'd21); hold("R7"); hold("R7"); idle("R7", 0);
        for (int i = 0; i < 1500; i++) rand_step();
        repeat (3) idle("", 0);

        report();
        $finish;
    end

endmodule